// File: doc/BRIEF.md
# Serial Link GPIO Status Slot Shadow

This block sits on the receive side of a 256-bit-per-frame serial audio/modem codec link. It follows the incoming bit stream, one bit per falling edge of the link bit clock, and keeps its frame position aligned to the frame-start marker. At the end of the twelfth data slot, it copies that slot into a local shadow register. It does so only when the tag slot of the same frame flagged slot 12 as valid. Slot 12 carries the codec's input GPIO pin levels in its upper 16 bits and a GPIO interrupt event in its bit 0.

A simple register-read port sits beside the link logic. A read to the GPIO status codec address (0x54) is answered locally from the shadow, one cycle later, and never produces a link transaction. Any other codec address is passed unchanged to a forward port, which the command-slot logic elsewhere in the controller uses. The interrupt bit of the latest captured slot is driven continuously on a flag output.

The link inputs are treated as synchronous to the system clock. The bench runs the bit clock well below the system clock.

Top module: `slot12_status_shadow`

## Requirements
- R1: After reset the shadow is zero: a status read returns 0x0000, `gpiIrq` is 0, and `rdValid` and `fwdValid` are 0.
- R2: Frame bit 0 is the first bit sampled after a rising edge of `sync`. Slot 12 occupies frame bits 236 to 255, sent MSB first. When tag bit 3 (frame bit 12) is 1, slot 12 is captured. A later status read then returns slot bits 19 to 4.
- R3: When tag bit 3 of a frame is 0, the shadow keeps its previous value.
- R4: `gpiIrq` equals bit 0 of the most recently captured slot 12.
- R5: A read with `rdAddr` equal to 0x54 gives `rdValid` high for one cycle on the next cycle, with the shadow data on `rdData`. `fwdValid` stays low.
- R6: A read to any other address gives `fwdValid` high for one cycle on the next cycle, with `fwdAddr` equal to the address read. `rdValid` stays low.
- R7: When several valid frames arrive, the status read returns the data of the most recent one.
- R8: A rising edge of `sync` restarts frame position 0. A frame cut short by a new `sync` captures nothing, and the following full frame is captured at its own positions.
- R9: Before the first rising edge of `sync` after reset, no bits are counted and the shadow does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitClk | input | 1 | Link bit clock, sampled by clk; data is taken on its falling edge |
| sync | input | 1 | Frame marker, high during the 16 tag bits |
| sdataIn | input | 1 | Serial data from the codec |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 7 | Codec register address of the read |
| rdValid | output | 1 | Local read answer valid (one cycle) |
| rdData | output | 16 | GPIO status from the shadow |
| fwdValid | output | 1 | Read forwarded to the link (one cycle) |
| fwdAddr | output | 7 | Address of the forwarded read |
| gpiIrq | output | 1 | GPIO interrupt event bit of the latest captured slot |

## Verification
The hardest cases to reach are frame-alignment corners. These are a frame cut short by an early `sync`, and bits that arrive before any `sync` has been seen. Neither changes an output at the moment it happens. The bench builds every frame bit by bit with a serializer task. It can drop the `sync` pulse or truncate a frame at a chosen bit, and it then checks through a status read that the shadow was left alone or was realigned.

// File: rtl/slotcap_pkg.sv
package slotcap_pkg;
  // Strobes from the control to the datapath, one group per system cycle
  typedef struct packed {
    logic shiftEn;     // take one serial bit into the shift register
    logic shadowLoad;  // last bit of the status slot: copy into shadow
    logic rdLocal;     // status read answered from the shadow
    logic rdFwd;       // read passed to the forward port
  } slotStrb_t;
endpackage

// File: rtl/slotcap_ctl.sv
module slotcap_ctl
  import slotcap_pkg::*;
#(
  parameter int TAG_W       = 16,
  parameter int SLOT_W      = 20,
  parameter int NUM_SLOTS   = 12,
  parameter int TARGET_SLOT = 12,
  parameter int ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              sync,
  input  logic              sdataIn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output slotStrb_t         strb
);
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int END_INT   = TAG_W + TARGET_SLOT * SLOT_W - 1;
  // tag bit (TAG_W-1-n) flags slot n; sent MSB first, so frame position n
  localparam logic [CNT_W-1:0] TAG_POS  = CNT_W'(TARGET_SLOT);
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(END_INT);

  logic             bitClkQ;
  logic             syncPrev;
  logic             active;
  logic             tagOk;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curIdx;
  logic             bitFall;
  logic             syncRise;
  logic             counting;

  assign bitFall  = bitClkQ & ~bitClk;
  assign syncRise = bitFall & sync & ~syncPrev;
  assign counting = bitFall & (active | syncRise);

  always_comb begin
    if (syncRise) curIdx = '0;
    else          curIdx = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitClkQ  <= 1'b1;
      syncPrev <= 1'b0;
      active   <= 1'b0;
      tagOk    <= 1'b0;
      cnt      <= '0;
    end else begin
      bitClkQ <= bitClk;
      if (bitFall) syncPrev <= sync;
      if (syncRise) active <= 1'b1;
      if (counting) begin
        cnt <= curIdx;
        if (curIdx == '0)     tagOk <= 1'b0;
        if (curIdx == TAG_POS) tagOk <= sdataIn;
      end
    end
  end

  always_comb begin
    strb.shiftEn    = counting;
    strb.shadowLoad = counting && (curIdx == SLOT_END) && tagOk;
    strb.rdLocal    = rdEn && (rdAddr == STATUS_ADDR);
    strb.rdFwd      = rdEn && (rdAddr != STATUS_ADDR);
  end

  // R8
  sync_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncRise |=> (cnt == '0));

  // R2
  load_at_slot_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shadowLoad |=> (cnt == SLOT_END));

  // R9
  idle_no_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !(bitFall && sync)) |=> $stable(cnt));
endmodule

// File: rtl/slotcap_dp.sv
module slotcap_dp
  import slotcap_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrb_t         strb,
  input  logic              sdataIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              gpiIrq
);
  // shift holds the first SLOT_W-1 bits; the last bit comes from sdataIn
  localparam int SH_W = SLOT_W - 1;

  logic [SH_W-1:0]   shift;
  logic [DATA_W-1:0] statusQ;
  logic              irqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shift   <= '0;
      statusQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strb.shiftEn) shift <= {shift[SH_W-2:0], sdataIn};
      if (strb.shadowLoad) begin
        statusQ <= shift[SH_W-1 -: DATA_W];
        irqQ    <= sdataIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
    end else begin
      rdValid  <= strb.rdLocal;
      fwdValid <= strb.rdFwd;
      if (strb.rdLocal) rdData  <= statusQ;
      if (strb.rdFwd)   fwdAddr <= rdAddr;
    end
  end

  assign gpiIrq = irqQ;

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shadowLoad |=> ($stable(statusQ) && $stable(irqQ)));
endmodule

// File: rtl/slot12_status_shadow.sv
module slot12_status_shadow
  import slotcap_pkg::*;
#(
  parameter int TAG_W       = 16,
  parameter int SLOT_W      = 20,
  parameter int NUM_SLOTS   = 12,
  parameter int TARGET_SLOT = 12,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h54
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              sync,
  input  logic              sdataIn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic              gpiIrq
);
  slotStrb_t strb;

  slotcap_ctl #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS),
    .TARGET_SLOT(TARGET_SLOT), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .sync(sync),
    .sdataIn(sdataIn), .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  slotcap_dp #(
    .SLOT_W(SLOT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdataIn(sdataIn),
    .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .gpiIrq(gpiIrq)
  );

  // R5
  local_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == STATUS_ADDR) |=> (rdValid && !fwdValid));

  // R6
  fwd_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr != STATUS_ADDR) |=> (fwdValid && !rdValid && fwdAddr == $past(rdAddr)));

  // R5
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && fwdValid));
endmodule

// File: tb/slot12_status_shadow_test.sv
`timescale 1ns/1ps
module slot12_status_shadow_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b1;
  logic sync = 1'b0;
  logic sdataIn = 1'b0;
  logic rdEn = 1'b0;
  logic [6:0] rdAddr = '0;
  logic rdValid, fwdValid, gpiIrq;
  logic [15:0] rdData;
  logic [6:0] fwdAddr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slot12_status_shadow uut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .sync(sync), .sdataIn(sdataIn),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .fwdValid(fwdValid), .fwdAddr(fwdAddr), .gpiIrq(gpiIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(logic s, logic d);
    @(negedge clk); sync = s; sdataIn = d; bitClk = 1'b1;
    repeat (2) @(negedge clk);
    bitClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Sends frame bits 0..nBits-1; tag bit 3 at position 12, slot 12 at 236..255
  task automatic sendFrame(logic tag3, logic [19:0] slot, bit withSync, int nBits);
    for (int i = 0; i < nBits; i++) begin
      logic d;
      if (i < 16)       d = (i == 0) ? 1'b1 : (i == 12) ? tag3 : i[0];
      else if (i < 236) d = i[1] ^ i[3];
      else              d = slot[255 - i];
      sendBit(withSync && (i < 16), d);
    end
    @(negedge clk); sync = 1'b0;
  endtask

  task automatic statusRead(string req, logic [15:0] expData);
    @(negedge clk); rdEn = 1'b1; rdAddr = 7'h54;
    @(negedge clk); rdEn = 1'b0;
    check({req, " rdValid"}, {31'd0, rdValid}, 32'd1);
    check({req, " fwdValid"}, {31'd0, fwdValid}, 32'd0);
    check({req, " rdData"}, {16'd0, rdData}, {16'd0, expData});
    @(negedge clk);
    check({req, " rdValid pulse"}, {31'd0, rdValid}, 32'd0);
  endtask

  task automatic testReset();
    check("R1 rdValid", {31'd0, rdValid}, 32'd0);
    check("R1 fwdValid", {31'd0, fwdValid}, 32'd0);
    check("R1 gpiIrq", {31'd0, gpiIrq}, 32'd0);
    statusRead("R1", 16'h0000);
  endtask

  task automatic testNoSyncIdle();
    sendFrame(1'b1, 20'hABCDF, 1'b0, 256);
    statusRead("R9", 16'h0000);
    check("R9 gpiIrq", {31'd0, gpiIrq}, 32'd0);
  endtask

  task automatic testCapture();
    sendFrame(1'b1, 20'h5A3C1, 1'b1, 256);
    statusRead("R2", 16'h5A3C);
    check("R4 gpiIrq set", {31'd0, gpiIrq}, 32'd1);
  endtask

  task automatic testInvalidTag();
    sendFrame(1'b0, 20'h12340, 1'b1, 256);
    statusRead("R3", 16'h5A3C);
    check("R3 gpiIrq kept", {31'd0, gpiIrq}, 32'd1);
  endtask

  task automatic testMostRecent();
    sendFrame(1'b1, 20'hFFFF1, 1'b1, 256);
    sendFrame(1'b1, 20'hC0DE0, 1'b1, 256);
    statusRead("R7", 16'hC0DE);
    check("R4 gpiIrq clear", {31'd0, gpiIrq}, 32'd0);
  endtask

  task automatic testRealign();
    sendFrame(1'b1, 20'h77771, 1'b1, 120);
    statusRead("R8 truncated", 16'hC0DE);
    sendFrame(1'b1, 20'h2468F, 1'b1, 256);
    statusRead("R8 realigned", 16'h2468);
    check("R8 gpiIrq", {31'd0, gpiIrq}, 32'd1);
  endtask

  task automatic testForward(logic [6:0] a);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    @(negedge clk); rdEn = 1'b0;
    check("R6 fwdValid", {31'd0, fwdValid}, 32'd1);
    check("R6 fwdAddr", {25'd0, fwdAddr}, {25'd0, a});
    check("R6 rdValid", {31'd0, rdValid}, 32'd0);
    @(negedge clk);
    check("R6 fwdValid pulse", {31'd0, fwdValid}, 32'd0);
  endtask

  task automatic testLocalNoForward();
    statusRead("R5", 16'h2468);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testNoSyncIdle();
    testCapture();
    testInvalidTag();
    testMostRecent();
    testRealign();
    testForward(7'h26);
    testForward(7'h55);
    testForward(7'h00);
    testLocalNoForward();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule